// File: doc/BRIEF.md
# Serial Output Router with Fault Latch

This block steers three single-bit outputs of a serial transmit path. The main output and the loopback output each carry one serial stream, chosen between the internally serialized data and an external serial input that is passed through unchanged. The monitor output carries either the bit clock or a data stream, depending on a clock-select input. A disable input forces the main output low, and a loopback enable decides whether the loopback output is active. All routed outputs are registered, so each one follows its inputs by one clock.

Next to the router sits a laser-fault status latch. A rising edge on the laser alarm input sets the fault flag, and a falling edge on the fault reset input clears it. A level held on either input does nothing after its edge. Both inputs are sampled in the system clock domain through a short sampling chain of `IN_STAGES` registers, and an edge is found by comparing the last two samples. When a set and a clear arrive in the same cycle, the set wins.

Top module: `serial_route_fault`

## Requirements
- R1: When `main_dis` is high at a clock edge, `main_out` is low after that edge, whatever the other selects are.
- R2: When `main_dis` is low at a clock edge, `main_out` after that edge equals `ext_data` if `ext_sel` is high and `ser_data` if `ext_sel` is low. `lpbk_en` has no effect on it.
- R3: After a clock edge, `lpbk_out` equals the stream chosen by `ext_sel` (as in R2) when `lpbk_en` was high and `main_dis` low at that edge. Otherwise it is low.
- R4: When `mon_data_sel` is low at a clock edge, `mon_out` equals `bit_clk` after that edge, for every setting of the other selects.
- R5: When `mon_data_sel` is high at a clock edge, `mon_out` after that edge equals `ser_data` if `ext_sel` is high and is low if `ext_sel` is low.
- R6: While `rst` is high at a clock edge, all four outputs are low after that edge.
- R7: A 0-to-1 change of `laser_alarm` sets `fault_flag`. With `IN_STAGES` = N, the flag is high after the N-th clock edge, counting from the first edge that samples the new level.
- R8: A 1-to-0 change of `fault_clear` clears `fault_flag`, with the same latency as R7. A constant level on `laser_alarm` or `fault_clear` leaves the flag unchanged.
- R9: If a set edge (R7) and a clear edge (R8) take effect at the same clock edge, `fault_flag` goes high.
- R10: After reset, `fault_flag` is low and both sample chains hold low. An alarm that is high when reset is released therefore counts as a rising edge. A clear input that is high at release is not a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Internally serialized data |
| bit_clk | input | 1 | Bit clock, used as a level for monitoring |
| ext_data | input | 1 | External serial input, passed through unchanged |
| mon_data_sel | input | 1 | Low: bit clock on the monitor output; high: data or low |
| ext_sel | input | 1 | High: the external input feeds the data paths |
| lpbk_en | input | 1 | Loopback output enable |
| main_dis | input | 1 | Forces the main output low |
| laser_alarm | input | 1 | Laser alarm; its rising edge sets the fault flag |
| fault_clear | input | 1 | Fault reset; its falling edge clears the fault flag |
| main_out | output | 1 | Routed main serial output |
| lpbk_out | output | 1 | Routed loopback output |
| mon_out | output | 1 | Routed monitor output |
| fault_flag | output | 1 | Latched laser fault status |

## Verification
The bench builds the block with its default `IN_STAGES` of 2. The edge latency is then short enough that single-cycle alarm and clear pulses are easy to place, and a set edge and a clear edge can be lined up on the same clock edge to test the priority rule. Random sweeps over all sixteen select combinations cover the whole routing map for both data sources. Directed sequences hold the alarm and clear inputs at fixed levels after their edges, and release reset with both inputs high.

// File: rtl/srf_pkg.sv
package srf_pkg;

  // Routing controls as seen at one clock edge.
  typedef struct packed {
    logic mon_data;  // 0: bit clock to monitor, 1: data or low
    logic ext;       // 1: external input drives the data paths
    logic lpbk;      // loopback enable
    logic dis;       // main output disable
  } route_ctrl_t;

  // Which change of level a sampler reports.
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

endpackage

// File: rtl/srf_edge_sampler.sv
module srf_edge_sampler
  import srf_pkg::*;
#(
  parameter int         STAGES = 2,
  parameter edge_kind_e KIND   = EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_pulse
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  // Sampling chain; the last two samples are compared.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i <= LAST; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign edge_pulse = chain[LAST-1] & ~chain[LAST];
    end else begin : g_fall
      assign edge_pulse = ~chain[LAST-1] & chain[LAST];
    end
  endgenerate

endmodule

// File: rtl/srf_fault_latch.sv
module srf_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr_pulse,
  output logic flag
);

  // The set pulse takes priority over the clear pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (set_pulse) begin
      flag <= 1'b1;
    end else if (clr_pulse) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/srf_router.sv
module srf_router
  import srf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  route_ctrl_t ctrl,
  input  logic        ser_data,
  input  logic        ext_data,
  input  logic        bit_clk,
  output logic        main_q,
  output logic        lpbk_q,
  output logic        mon_q
);

  logic stream;
  logic main_d;
  logic lpbk_d;
  logic mon_d;

  always_comb begin
    stream = ctrl.ext ? ext_data : ser_data;
    main_d = ctrl.dis ? 1'b0 : stream;
    lpbk_d = (ctrl.lpbk && !ctrl.dis) ? stream : 1'b0;
    if (!ctrl.mon_data) begin
      mon_d = bit_clk;
    end else begin
      mon_d = ctrl.ext ? ser_data : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= 1'b0;
      lpbk_q <= 1'b0;
      mon_q  <= 1'b0;
    end else begin
      main_q <= main_d;
      lpbk_q <= lpbk_d;
      mon_q  <= mon_d;
    end
  end

endmodule

// File: rtl/serial_route_fault.sv
module serial_route_fault
  import srf_pkg::*;
#(
  parameter int IN_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_data,
  input  logic bit_clk,
  input  logic ext_data,
  input  logic mon_data_sel,
  input  logic ext_sel,
  input  logic lpbk_en,
  input  logic main_dis,
  input  logic laser_alarm,
  input  logic fault_clear,
  output logic main_out,
  output logic lpbk_out,
  output logic mon_out,
  output logic fault_flag
);

  localparam int STAGES = (IN_STAGES < 2) ? 2 : IN_STAGES;

  route_ctrl_t ctrl;
  logic        set_pulse;
  logic        clr_pulse;

  assign ctrl = '{mon_data: mon_data_sel, ext: ext_sel,
                  lpbk: lpbk_en, dis: main_dis};

  srf_router u_router (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .ser_data (ser_data),
    .ext_data (ext_data),
    .bit_clk  (bit_clk),
    .main_q   (main_out),
    .lpbk_q   (lpbk_out),
    .mon_q    (mon_out)
  );

  srf_edge_sampler #(.STAGES(STAGES), .KIND(EDGE_RISE)) u_alarm_edge (
    .clk        (clk),
    .rst        (rst),
    .din        (laser_alarm),
    .edge_pulse (set_pulse)
  );

  srf_edge_sampler #(.STAGES(STAGES), .KIND(EDGE_FALL)) u_clear_edge (
    .clk        (clk),
    .rst        (rst),
    .din        (fault_clear),
    .edge_pulse (clr_pulse)
  );

  srf_fault_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (set_pulse),
    .clr_pulse (clr_pulse),
    .flag      (fault_flag)
  );

endmodule

// File: rtl/srf_checker.sv
module srf_checker (
  input logic clk,
  input logic rst,
  input logic ser_data,
  input logic bit_clk,
  input logic ext_data,
  input logic mon_data_sel,
  input logic ext_sel,
  input logic lpbk_en,
  input logic main_dis,
  input logic laser_alarm,
  input logic fault_clear,
  input logic main_out,
  input logic lpbk_out,
  input logic mon_out,
  input logic fault_flag
);

  assert_main_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    $past(main_dis) |-> !main_out);

  assert_main_stream_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(main_dis)) |->
      main_out == ($past(ext_sel) ? $past(ext_data) : $past(ser_data)));

  assert_loopback_route_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      lpbk_out == (($past(lpbk_en) && !$past(main_dis)) &&
                   ($past(ext_sel) ? $past(ext_data) : $past(ser_data))));

  assert_monitor_clock_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mon_data_sel)) |-> mon_out == $past(bit_clk));

  assert_monitor_data_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mon_data_sel)) |->
      mon_out == ($past(ext_sel) && $past(ser_data)));

  assert_reset_outputs_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!main_out && !lpbk_out && !mon_out && !fault_flag));

endmodule

bind serial_route_fault srf_checker u_srf_checker (.*);

// File: tb/serial_route_fault_bench.sv
module serial_route_fault_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 2;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_data = 0, bit_clk = 0, ext_data = 0;
  logic mon_data_sel = 0, ext_sel = 0, lpbk_en = 0, main_dis = 0;
  logic laser_alarm = 0, fault_clear = 0;
  logic main_out, lpbk_out, mon_out, fault_flag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_route_fault #(.IN_STAGES(N)) u_serial_route_fault (
    .clk(clk), .rst(rst), .ser_data(ser_data), .bit_clk(bit_clk),
    .ext_data(ext_data), .mon_data_sel(mon_data_sel), .ext_sel(ext_sel),
    .lpbk_en(lpbk_en), .main_dis(main_dis), .laser_alarm(laser_alarm),
    .fault_clear(fault_clear), .main_out(main_out), .lpbk_out(lpbk_out),
    .mon_out(mon_out), .fault_flag(fault_flag)
  );

  // Reference model: histories of sampled alarm/clear levels, updated per edge.
  bit alarm_hist[$];
  bit clear_hist[$];
  bit exp_main, exp_lpbk, exp_mon, exp_fault;
  string tag_main, tag_lpbk, tag_mon, tag_fault;

  always @(posedge clk) begin
    bit stream, set_e, clr_e;
    if (rst) begin
      alarm_hist = {};
      clear_hist = {};
      for (int i = 0; i < N; i++) begin
        alarm_hist.push_back(1'b0);
        clear_hist.push_back(1'b0);
      end
      exp_main = 0; exp_lpbk = 0; exp_mon = 0; exp_fault = 0;
      tag_main = "R6"; tag_lpbk = "R6"; tag_mon = "R6"; tag_fault = "R10";
    end else begin
      // index 0 newest sample, index N-1 oldest
      set_e = alarm_hist[N-2] && !alarm_hist[N-1];
      clr_e = !clear_hist[N-2] && clear_hist[N-1];
      if (set_e && clr_e) tag_fault = "R9";
      else if (set_e)     tag_fault = "R7";
      else                tag_fault = "R8";
      if (set_e)      exp_fault = 1;
      else if (clr_e) exp_fault = 0;
      void'(alarm_hist.pop_back());
      void'(clear_hist.pop_back());
      alarm_hist.push_front(laser_alarm);
      clear_hist.push_front(fault_clear);

      stream   = ext_sel ? ext_data : ser_data;
      exp_main = main_dis ? 1'b0 : stream;
      tag_main = main_dis ? "R1" : "R2";
      exp_lpbk = (lpbk_en && !main_dis) ? stream : 1'b0;
      tag_lpbk = "R3";
      exp_mon  = mon_data_sel ? (ext_sel && ser_data) : bit_clk;
      tag_mon  = mon_data_sel ? "R5" : "R4";
    end
  end

  task automatic check(input string req, input string what,
                       input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(tag_main,  "main_out",   main_out,   exp_main);
    check(tag_lpbk,  "lpbk_out",   lpbk_out,   exp_lpbk);
    check(tag_mon,   "mon_out",    mon_out,    exp_mon);
    check(tag_fault, "fault_flag", fault_flag, exp_fault);
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs.
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic rand_route();
    {mon_data_sel, ext_sel, lpbk_en, main_dis} = 4'($urandom);
    {ser_data, bit_clk, ext_data} = 3'($urandom);
  endtask

  task automatic set_fault_pins(input bit a, input bit c);
    laser_alarm = a;
    fault_clear = c;
  endtask

  initial begin
    // Reset state (R6, R10)
    repeat (3) step();
    check("R6", "main_out after reset", main_out, 1'b0);
    check("R10", "fault_flag after reset", fault_flag, 1'b0);
    rst = 0;

    // Routing sweep over all selects with alarm/clear quiet (R1..R5)
    for (int i = 0; i < 400; i++) begin
      step();
      rand_route();
    end

    // Single-cycle alarm pulse sets the flag (R7)
    step(); set_fault_pins(1, 0);
    step(); set_fault_pins(0, 0);
    repeat (3) step();
    check("R7", "fault_flag after alarm pulse", fault_flag, 1'b1);

    // Alarm held high, clear pulses: flag cleared and stays low (R8)
    step(); set_fault_pins(1, 0);
    repeat (4) step();
    set_fault_pins(1, 1);
    step(); set_fault_pins(1, 0);
    repeat (6) step();
    check("R8", "fault_flag with alarm level held", fault_flag, 1'b0);

    // Clear held low for long: no change (R8)
    repeat (5) step();
    check("R8", "fault_flag clear level held", fault_flag, 1'b0);

    // Simultaneous set and clear edges (R9)
    set_fault_pins(0, 1);
    repeat (4) step();
    set_fault_pins(1, 0);
    repeat (4) step();
    check("R9", "fault_flag set wins", fault_flag, 1'b1);

    // Random alarm/clear activity with routing (R7, R8, R9)
    for (int i = 0; i < 600; i++) begin
      step();
      rand_route();
      set_fault_pins(1'($urandom), 1'($urandom));
    end

    // Reset released with both inputs high (R10)
    step(); rst = 1; set_fault_pins(1, 1);
    repeat (3) step();
    rst = 0;
    repeat (4) step();
    check("R10", "alarm high at release sets flag", fault_flag, 1'b1);
    repeat (3) step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule